// File: doc/BRIEF.md
# Sideband Reply Segmenter

This block takes a reply message that already sits in a byte buffer and hands it to a host in pieces through a small reply window. The message is cut into chunks of at most `MAX_PAY` payload bytes (44 by default). For every chunk the block reads the payload from the buffer and writes it into the window starting at offset 3. It appends a CRC8 over the payload, then writes a freshly built 3-byte header with its own CRC4 at offsets 0 to 2.

Once a chunk is complete in the window, the block posts it. It loads an event status register with the port count and a reply-ready flag and pulses an interrupt. It then waits. The host reads the window and acknowledges the chunk by writing a one to the ready bit, which clears it. Only after that clear does the next chunk begin. A `busy` output covers the whole message, from the accepted start strobe until the host acknowledges the last chunk.

Top module: `sb_reply_segmenter`

## Requirements
- R1: A message of L bytes is split into ceil(L/MAX_PAY) chunks. Chunk k carries buffer bytes k*MAX_PAY onward, min(MAX_PAY, L-k*MAX_PAY) of them, and the last chunk takes the remainder. One interrupt pulse is issued per chunk.
- R2: Header byte 0 is 0x10: the link count total of 1 is in bits 7:4 and the remaining count of 0 is in bits 3:0. In header byte 1, bit 7 (broadcast) and bit 6 (path message) are 0, and bits 5:0 hold the chunk payload length plus one.
- R3: Header byte 2 has these fields:
  - bit 7: start flag, set only on the first chunk.
  - bit 6: end flag, set only on the chunk that completes the message.
  - bit 5: 0.
  - bit 4: the sequence number latched at start.
  - bits 3:0: a CRC4 with polynomial x^4+x+1 and zero initial value, taken MSB first over header byte 0, header byte 1 and bits 7:4 of header byte 2.
- R4: Payload bytes are placed at window offsets 3 to 3+n-1 in buffer order. Offset 3+n holds a CRC8 of the payload: polynomial 0xD5 with the x^8 term implied, zero initial value, MSB first.
- R5: When a chunk is complete, status byte 0 takes `port_count`, status byte 1 takes 0x10 (the ready bit is bit 4) and status byte 2 takes 0. `irq` pulses high for exactly one cycle after all window writes of that chunk.
- R6: A host status write clears exactly the bits of the addressed byte where the write data is 1, and leaves the other bits unchanged. A write with bit 4 at 0 does not release a chunk.
- R7: While the ready bit is set, the block issues no window write, no buffer read and no further interrupt. The next chunk starts only after the host clears the ready bit.
- R8: `busy` rises the cycle after an accepted start and falls after the host acknowledges the last chunk. A start while busy is ignored, and so is a start with length 0.
- R9: After reset, `busy` and `irq` are 0 and every status byte is 0. `st_rd_data` returns the status byte at `st_rd_addr` one cycle after the address is presented.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start strobe for a new reply message |
| start_len | input | clog2(MAX_MSG+1) (9) | Message length in bytes |
| start_seq | input | 1 | Sequence number copied into every header |
| port_count | input | 8 | Value posted into status byte 0 |
| buf_rd_en | output | 1 | Buffer read enable |
| buf_rd_addr | output | clog2(MAX_MSG) (8) | Buffer read address |
| buf_rd_data | input | 8 | Buffer read data, valid one cycle after the read enable |
| win_wr_en | output | 1 | Reply window write enable |
| win_wr_addr | output | clog2(MAX_PAY+4) (6) | Reply window byte offset |
| win_wr_data | output | 8 | Reply window write data |
| st_wr_en | input | 1 | Host write-one-to-clear strobe |
| st_wr_addr | input | clog2(STAT_BYTES) (4) | Status byte written by the host |
| st_wr_data | input | 8 | Bits to clear |
| st_rd_addr | input | clog2(STAT_BYTES) (4) | Status byte read address |
| st_rd_data | output | 8 | Status read data, registered |
| irq | output | 1 | One-cycle interrupt per posted chunk |
| busy | output | 1 | High while a message is in progress |

## Verification
The bench builds the block with MAX_MSG=32 and MAX_PAY=5, so that short messages already span many chunks. It sweeps every length from 1 to 17 and also 31 and 32, which covers single-chunk messages, lengths that are exact multiples of the chunk size and remainders of each size, including the largest message. Every chunk's header, payload, CRC8, status bytes and the stall under a partial clear are compared against values computed arithmetically in the bench.

// File: rtl/sbr_pkg.sv
package sbr_pkg;

  typedef enum logic [3:0] {
    S_IDLE, S_LOAD, S_RD, S_WR, S_CRC, S_H0, S_H1, S_H2, S_POST, S_WAIT
  } sbr_state_e;

  // one byte through an MSB-first CRC8 (non-augmented form)
  function automatic logic [7:0] crc8_step(input logic [7:0] c_in,
                                           input logic [7:0] d,
                                           input logic [7:0] poly);
    logic [7:0] c;
    logic fb;
    c = c_in;
    for (int i = 7; i >= 0; i--) begin
      fb = c[7] ^ d[i];
      c  = {c[6:0], 1'b0};
      if (fb) c = c ^ poly;
    end
    return c;
  endfunction

  // one nibble through an MSB-first CRC4 (non-augmented form)
  function automatic logic [3:0] crc4_step(input logic [3:0] c_in,
                                           input logic [3:0] n,
                                           input logic [3:0] poly);
    logic [3:0] c;
    logic fb;
    c = c_in;
    for (int i = 3; i >= 0; i--) begin
      fb = c[3] ^ n[i];
      c  = {c[2:0], 1'b0};
      if (fb) c = c ^ poly;
    end
    return c;
  endfunction

endpackage

// File: rtl/sbr_crc8_acc.sv
module sbr_crc8_acc #(
  parameter logic [7:0] POLY = 8'hD5
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       clr,
  input  logic       en,
  input  logic [7:0] din,
  output logic [7:0] crc
);
  import sbr_pkg::*;

  always_ff @(posedge clk) begin
    if (rst || clr) crc <= '0;
    else if (en)    crc <= crc8_step(crc, din, POLY);
  end

endmodule

// File: rtl/sbr_hdr_build.sv
module sbr_hdr_build #(
  parameter int MAX_PAY = 44,
  parameter int PAY_W   = $clog2(MAX_PAY + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hdr_en,
  input  logic             first,
  input  logic             last,
  input  logic             seq,
  input  logic [PAY_W-1:0] pay_len,
  output logic [7:0]       h0,
  output logic [7:0]       h1,
  output logic [7:0]       h2
);
  import sbr_pkg::*;

  localparam logic [3:0] LCT   = 4'd1;
  localparam logic [3:0] LCR   = 4'd0;
  localparam logic [3:0] POLY4 = 4'h3;

  logic [3:0] hi2;
  logic [3:0] c4;

  always_comb begin
    h0  = {LCT, LCR};
    h1  = {1'b0, 1'b0, 6'(pay_len) + 6'd1};
    hi2 = {first, last, 1'b0, seq};
    c4  = 4'd0;
    c4  = crc4_step(c4, h0[7:4], POLY4);
    c4  = crc4_step(c4, h0[3:0], POLY4);
    c4  = crc4_step(c4, h1[7:4], POLY4);
    c4  = crc4_step(c4, h1[3:0], POLY4);
    c4  = crc4_step(c4, hi2, POLY4);
    h2  = {hi2, c4};
  end

  AST_CHUNK_LEN: assert property (@(posedge clk) disable iff (rst)
    hdr_en |-> (pay_len != '0 && pay_len <= PAY_W'(MAX_PAY))); // R1

endmodule

// File: rtl/sbr_status_regs.sv
module sbr_status_regs #(
  parameter int STAT_BYTES = 16,
  parameter int RDY_BIT    = 4,
  parameter int SA_W       = $clog2(STAT_BYTES)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            post_set,
  input  logic [7:0]      port_count,
  input  logic            wr_en,
  input  logic [SA_W-1:0] wr_addr,
  input  logic [7:0]      wr_data,
  input  logic [SA_W-1:0] rd_addr,
  output logic [7:0]      rd_data,
  output logic            rdy
);

  localparam int POSTED = 3;

  logic [7:0] flat [STAT_BYTES];

  for (genvar g = 0; g < STAT_BYTES; g++) begin : g_byte
    logic [7:0] r;
    logic       hit;
    assign hit = wr_en && (wr_addr == SA_W'(g));

    if (g < POSTED) begin : g_post
      logic [7:0] pv;
      if (g == 0) begin : g_p0
        assign pv = port_count;
      end else if (g == 1) begin : g_p1
        assign pv = 8'(1 << RDY_BIT);
      end else begin : g_p2
        assign pv = 8'd0;
      end
      always_ff @(posedge clk) begin
        if (rst)           r <= '0;
        else if (post_set) r <= pv;
        else if (hit)      r <= r & ~wr_data;
      end
    end else begin : g_plain
      always_ff @(posedge clk) begin
        if (rst)      r <= '0;
        else if (hit) r <= r & ~wr_data;
      end
    end

    assign flat[g] = r;
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= flat[rd_addr];
  end

  assign rdy = flat[1][RDY_BIT];

  AST_POST_SETS_RDY: assert property (@(posedge clk) disable iff (rst)
    post_set |=> rdy); // R5

  AST_W1C_RDY: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !post_set && wr_addr == SA_W'(1) && wr_data[RDY_BIT]) |=> !rdy); // R6

  AST_RDY_HOLD: assert property (@(posedge clk) disable iff (rst)
    (rdy && !(wr_en && wr_addr == SA_W'(1) && wr_data[RDY_BIT])) |=> rdy); // R6

endmodule

// File: rtl/sb_reply_segmenter.sv
module sb_reply_segmenter #(
  parameter int MAX_MSG    = 256,
  parameter int MAX_PAY    = 44,
  parameter int STAT_BYTES = 16,
  parameter int RDY_BIT    = 4
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            start,
  input  logic [$clog2(MAX_MSG+1)-1:0]    start_len,
  input  logic                            start_seq,
  input  logic [7:0]                      port_count,
  output logic                            buf_rd_en,
  output logic [$clog2(MAX_MSG)-1:0]      buf_rd_addr,
  input  logic [7:0]                      buf_rd_data,
  output logic                            win_wr_en,
  output logic [$clog2(MAX_PAY+4)-1:0]    win_wr_addr,
  output logic [7:0]                      win_wr_data,
  input  logic                            st_wr_en,
  input  logic [$clog2(STAT_BYTES)-1:0]   st_wr_addr,
  input  logic [7:0]                      st_wr_data,
  input  logic [$clog2(STAT_BYTES)-1:0]   st_rd_addr,
  output logic [7:0]                      st_rd_data,
  output logic                            irq,
  output logic                            busy
);
  import sbr_pkg::*;

  localparam int MSG_W     = $clog2(MAX_MSG + 1);
  localparam int BUF_AW    = $clog2(MAX_MSG);
  localparam int WIN_AW    = $clog2(MAX_PAY + 4);
  localparam int PAY_W     = $clog2(MAX_PAY + 1);
  localparam int SA_W      = $clog2(STAT_BYTES);
  localparam int HDR_BYTES = 3;

  sbr_state_e       state;
  logic [MSG_W-1:0] msg_len, pos, remain;
  logic [PAY_W-1:0] clen, idx, next_clen;
  logic             seq_q, irq_q, busy_q;
  logic             wr_en_q;
  logic [WIN_AW-1:0] wr_addr_q;
  logic [7:0]       wr_data_q;
  logic             first, last, rdy, post_set;
  logic [7:0]       crc8, h0, h1, h2;

  assign remain    = msg_len - pos;
  assign next_clen = (remain > MSG_W'(MAX_PAY)) ? PAY_W'(MAX_PAY) : remain[PAY_W-1:0];
  assign first     = (pos == '0);
  assign last      = ((pos + MSG_W'(clen)) == msg_len);
  assign post_set  = (state == S_POST);

  assign buf_rd_en   = (state == S_RD);
  assign buf_rd_addr = pos[BUF_AW-1:0] + BUF_AW'(idx);
  assign win_wr_en   = wr_en_q;
  assign win_wr_addr = wr_addr_q;
  assign win_wr_data = wr_data_q;
  assign irq         = irq_q;
  assign busy        = busy_q;

  sbr_crc8_acc #(.POLY(8'hD5)) u_crc8 (
    .clk (clk),
    .rst (rst),
    .clr (state == S_LOAD),
    .en  (state == S_WR),
    .din (buf_rd_data),
    .crc (crc8)
  );

  sbr_hdr_build #(.MAX_PAY(MAX_PAY), .PAY_W(PAY_W)) u_hdr (
    .clk     (clk),
    .rst     (rst),
    .hdr_en  (state == S_H0 || state == S_H1 || state == S_H2),
    .first   (first),
    .last    (last),
    .seq     (seq_q),
    .pay_len (clen),
    .h0      (h0),
    .h1      (h1),
    .h2      (h2)
  );

  sbr_status_regs #(.STAT_BYTES(STAT_BYTES), .RDY_BIT(RDY_BIT), .SA_W(SA_W)) u_stat (
    .clk        (clk),
    .rst        (rst),
    .post_set   (post_set),
    .port_count (port_count),
    .wr_en      (st_wr_en),
    .wr_addr    (st_wr_addr),
    .wr_data    (st_wr_data),
    .rd_addr    (st_rd_addr),
    .rd_data    (st_rd_data),
    .rdy        (rdy)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= S_IDLE;
      msg_len   <= '0;
      pos       <= '0;
      clen      <= '0;
      idx       <= '0;
      seq_q     <= 1'b0;
      irq_q     <= 1'b0;
      busy_q    <= 1'b0;
      wr_en_q   <= 1'b0;
      wr_addr_q <= '0;
      wr_data_q <= '0;
    end else begin
      wr_en_q <= 1'b0;
      irq_q   <= 1'b0;
      case (state)
        S_IDLE: begin
          if (start && start_len != '0 && start_len <= MSG_W'(MAX_MSG)) begin
            msg_len <= start_len;
            seq_q   <= start_seq;
            pos     <= '0;
            busy_q  <= 1'b1;
            state   <= S_LOAD;
          end
        end
        S_LOAD: begin
          clen  <= next_clen;
          idx   <= '0;
          state <= S_RD;
        end
        S_RD: state <= S_WR;
        S_WR: begin
          wr_en_q   <= 1'b1;
          wr_addr_q <= WIN_AW'(HDR_BYTES) + WIN_AW'(idx);
          wr_data_q <= buf_rd_data;
          idx       <= idx + 1'b1;
          state     <= (idx == clen - 1'b1) ? S_CRC : S_RD;
        end
        S_CRC: begin
          wr_en_q   <= 1'b1;
          wr_addr_q <= WIN_AW'(HDR_BYTES) + WIN_AW'(clen);
          wr_data_q <= crc8;
          state     <= S_H0;
        end
        S_H0: begin
          wr_en_q   <= 1'b1;
          wr_addr_q <= WIN_AW'(0);
          wr_data_q <= h0;
          state     <= S_H1;
        end
        S_H1: begin
          wr_en_q   <= 1'b1;
          wr_addr_q <= WIN_AW'(1);
          wr_data_q <= h1;
          state     <= S_H2;
        end
        S_H2: begin
          wr_en_q   <= 1'b1;
          wr_addr_q <= WIN_AW'(2);
          wr_data_q <= h2;
          pos       <= pos + MSG_W'(clen);
          state     <= S_POST;
        end
        S_POST: begin
          irq_q <= 1'b1;
          state <= S_WAIT;
        end
        S_WAIT: begin
          if (!rdy) begin
            if (pos == msg_len) begin
              busy_q <= 1'b0;
              state  <= S_IDLE;
            end else begin
              state <= S_LOAD;
            end
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (rst)
    irq |=> !irq); // R5

  AST_IRQ_WITH_RDY: assert property (@(posedge clk) disable iff (rst)
    irq |-> rdy); // R5

  AST_STALL_QUIET: assert property (@(posedge clk) disable iff (rst)
    rdy |-> (!win_wr_en && !buf_rd_en)); // R7

  AST_WIN_BOUND: assert property (@(posedge clk) disable iff (rst)
    win_wr_en |-> (win_wr_addr <= WIN_AW'(MAX_PAY + 3))); // R4

  AST_BUSY_RISE: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(start)); // R8

endmodule

// File: tb/sb_reply_segmenter_test.sv
module sb_reply_segmenter_test;
  localparam int CLK_PERIOD = 10;
  localparam int MAX_MSG    = 32;
  localparam int MAX_PAY    = 5;
  localparam int STAT_BYTES = 16;
  localparam int RDY_BIT    = 4;
  localparam int MSG_W      = $clog2(MAX_MSG + 1);
  localparam int BUF_AW     = $clog2(MAX_MSG);
  localparam int WIN_AW     = $clog2(MAX_PAY + 4);
  localparam int SA_W       = $clog2(STAT_BYTES);
  localparam logic [7:0] PORTS = 8'hA5;

  logic clk = 1'b0;
  logic rst;
  logic start;
  logic [MSG_W-1:0] start_len;
  logic start_seq;
  logic buf_rd_en;
  logic [BUF_AW-1:0] buf_rd_addr;
  logic [7:0] buf_rd_data;
  logic win_wr_en;
  logic [WIN_AW-1:0] win_wr_addr;
  logic [7:0] win_wr_data;
  logic st_wr_en;
  logic [SA_W-1:0] st_wr_addr, st_rd_addr;
  logic [7:0] st_wr_data, st_rd_data;
  logic irq, busy;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  int salt = 0;
  int win_wr_cnt = 0;
  int irq_cnt = 0;
  logic [7:0] win_m [0:(1<<WIN_AW)-1];

  always #(CLK_PERIOD/2) clk = ~clk;

  sb_reply_segmenter #(
    .MAX_MSG(MAX_MSG), .MAX_PAY(MAX_PAY), .STAT_BYTES(STAT_BYTES), .RDY_BIT(RDY_BIT)
  ) uut (
    .clk(clk), .rst(rst), .start(start), .start_len(start_len), .start_seq(start_seq),
    .port_count(PORTS), .buf_rd_en(buf_rd_en), .buf_rd_addr(buf_rd_addr),
    .buf_rd_data(buf_rd_data), .win_wr_en(win_wr_en), .win_wr_addr(win_wr_addr),
    .win_wr_data(win_wr_data), .st_wr_en(st_wr_en), .st_wr_addr(st_wr_addr),
    .st_wr_data(st_wr_data), .st_rd_addr(st_rd_addr), .st_rd_data(st_rd_data),
    .irq(irq), .busy(busy)
  );

  function automatic logic [7:0] pat(input int a);
    return 8'(a * 29 + 7 + salt);
  endfunction

  always @(posedge clk) begin
    if (buf_rd_en) buf_rd_data <= pat(int'(buf_rd_addr));
    if (win_wr_en) begin
      win_m[win_wr_addr] <= win_wr_data;
      win_wr_cnt++;
    end
    if (irq) irq_cnt++;
  end

  // augmented bitwise CRC4, 20 message bits then 4 zero bits
  function automatic logic [3:0] ref_crc4(input logic [19:0] bits);
    logic [4:0] r = 5'd0;
    for (int i = 19; i >= -4; i--) begin
      r = {r[3:0], (i >= 0) ? bits[i] : 1'b0};
      if (r[4]) r = r ^ 5'h13;
    end
    return r[3:0];
  endfunction

  // augmented bitwise CRC8 over pat(off .. off+n-1)
  function automatic logic [7:0] ref_crc8(input int off, input int n);
    logic [8:0] r = 9'd0;
    logic [7:0] b;
    for (int k = 0; k < n + 1; k++) begin
      b = (k < n) ? pat(off + k) : 8'd0;
      for (int i = 7; i >= 0; i--) begin
        r = {r[7:0], b[i]};
        if (r[8]) r = r ^ 9'h1D5;
      end
    end
    return r[7:0];
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic rd_stat(input int a, output logic [7:0] v);
    st_rd_addr = SA_W'(a);
    @(negedge clk);
    v = st_rd_data;
  endtask

  task automatic wr_stat(input int a, input logic [7:0] d);
    st_wr_en = 1'b1;
    st_wr_addr = SA_W'(a);
    st_wr_data = d;
    @(negedge clk);
    st_wr_en = 1'b0;
  endtask

  task automatic run_msg(input int len, input logic seq, input bit extra);
    int chunks, off, n, bad, wc, ic;
    logic [7:0] v;
    logic [7:0] e0, e1, e2;
    bit fst, lst;
    salt = len * 3;
    chunks = (len + MAX_PAY - 1) / MAX_PAY;
    ic = irq_cnt;
    start = 1'b1; start_len = MSG_W'(len); start_seq = seq;
    @(negedge clk);
    start = 1'b0;
    chk("R8 busy after start", int'(busy), 1);
    if (extra) begin
      start = 1'b1; start_len = MSG_W'(3); start_seq = ~seq;
      @(negedge clk);
      start = 1'b0;
    end
    for (int k = 0; k < chunks; k++) begin
      off = k * MAX_PAY;
      n = (len - off > MAX_PAY) ? MAX_PAY : len - off;
      fst = (k == 0);
      lst = (off + n == len);
      while (!irq) @(negedge clk);
      @(negedge clk);
      chk("R5 irq one cycle", int'(irq), 0);
      e0 = 8'h10;
      e1 = 8'(n + 1);
      e2 = {fst, lst, 1'b0, seq, ref_crc4({e0, e1, fst, lst, 1'b0, seq})};
      chk("R2 header byte0", int'(win_m[0]), int'(e0));
      chk("R2 R1 header byte1 length", int'(win_m[1]), int'(e1));
      chk("R3 header byte2 flags seq crc4", int'(win_m[2]), int'(e2));
      bad = 0;
      for (int i = 0; i < n; i++) if (win_m[3 + i] !== pat(off + i)) bad++;
      chk("R4 R1 payload mismatches", bad, 0);
      chk("R4 body crc8", int'(win_m[3 + n]), int'(ref_crc8(off, n)));
      rd_stat(0, v); chk("R5 status byte0", int'(v), int'(PORTS));
      rd_stat(1, v); chk("R5 status byte1", int'(v), 8'h10);
      rd_stat(2, v); chk("R5 status byte2", int'(v), 0);
      if (fst && extra) begin
        wr_stat(0, 8'h0F);
        rd_stat(0, v); chk("R6 partial clear byte0", int'(v), 8'hA0);
      end
      if (fst) begin
        wc = win_wr_cnt;
        wr_stat(1, 8'hEF);
        repeat (6) @(negedge clk);
        rd_stat(1, v); chk("R6 zero in ready bit keeps it", int'(v), 8'h10);
        chk("R7 no window write while stalled", win_wr_cnt, wc);
        chk("R7 no extra irq while stalled", irq_cnt - ic, 1);
      end
      wr_stat(1, 8'h10);
    end
    repeat (3) @(negedge clk);
    chk("R8 busy low after last ack", int'(busy), 0);
    chk("R1 interrupts per message", irq_cnt - ic, chunks);
  endtask

  initial begin
    logic [7:0] v;
    rst = 1'b1; start = 1'b0; start_len = '0; start_seq = 1'b0;
    st_wr_en = 1'b0; st_wr_addr = '0; st_wr_data = '0; st_rd_addr = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R9 reset busy", int'(busy), 0);
    chk("R9 reset irq", int'(irq), 0);
    for (int a = 0; a < 3; a++) begin
      rd_stat(a, v);
      chk("R9 reset status byte", int'(v), 0);
    end
    start = 1'b1; start_len = '0;
    @(negedge clk);
    start = 1'b0;
    chk("R8 zero length start ignored", int'(busy), 0);
    repeat (8) @(negedge clk);
    chk("R8 zero length gives no irq", irq_cnt, 0);
    for (int len = 1; len <= 17; len++) run_msg(len, 1'(len), len == 7);
    run_msg(31, 1'b1, 1'b0);
    run_msg(MAX_MSG, 1'b0, 1'b1);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule